// File: doc/BRIEF.md
# Addressable Serial Configuration Register Slave

This block receives 16-bit write frames from a serial bus that is shared by several devices. It keeps a small bank of 9-bit configuration registers and drives their contents in parallel to downstream logic. Each frame ends with a 3-bit device address. The frame takes effect only if that address equals the device's own strap pins, or if it is the shared all-devices address and the device has opted in to it. Readback is indirect. Register 0 holds a read pointer, and during the frame after the pointer write the selected register is shifted out on the serial output.

The serial clock, data and latch-enable pins are brought into the system clock domain by synchronizer stages and detected as edges there. A frame state machine has four states:
- `ST_HOLD`: latch enable high, waiting for it to drop.
- `ST_SHIFT`: counting bits.
- `ST_ARMED`: exactly 16 bits held.
- `ST_OVER`: a 17th bit arrived.

It has six transitions:
- HOLD→SHIFT when the latch enable is seen low. This starts a frame and loads the readback word.
- SHIFT→ARMED on the 16th serial-clock rise.
- SHIFT→HOLD on a latch rise before 16 bits. The frame is discarded, unless the 16th rise arrives in the same cycle, in which case it commits.
- ARMED→HOLD on a latch rise, which commits the frame.
- ARMED→OVER on an extra serial-clock rise.
- OVER→HOLD on a latch rise, which discards the frame.

Top module: `cfgspi_slave`

## Requirements
- R1: A frame is 16 bits sampled on serial-clock rising edges, MSB first: bits 15..7 are data d8:d0, bits 6..3 the register address, bits 2..0 the chip address. It is committed on the latch-enable rising edge that follows the 16th bit, including when that 16th rise and the latch rise are seen in the same cycle.
- R2: A frame whose chip address differs from the strap pins changes no register, unless R3 applies.
- R3: A frame addressed to 111 is accepted by a device with other straps only while register 4 bit 0 is 1. Otherwise it is ignored.
- R4: A frame with fewer or more than 16 bits before the latch rise is discarded, and no register changes.
- R5: At the start of each frame the register selected by register 0 bits [3:0] is loaded as the word {reg[8:0], 7'b0}. On the k-th serial-clock rise of the frame, the serial output takes bit 16-k of that word.
- R6: The output-enable is 0 after reset. It becomes 1 after a committed frame addressed to the strap value, becomes 0 after a committed frame with any other address (broadcast included), and is unchanged by discarded frames.
- R7: Reset defaults: reg0=0x000, reg1=0x00F, reg2=0x002, reg3=0x000, reg4=0x002, reg5=0x000, reg6=0x001, reg7=0x004.
- R8: A write to register 4 with bits 1 and 2 both 1 is rejected, and register 4 keeps its value.
- R9: An accepted write to register 0 with bit 4 set returns every register to its R7 default. No other field of that write is stored.
- R10: Writes to register addresses 8..15 change nothing. A pointer of 8..15 reads back as zero.
- R11: Register 0 stores only bits [3:0]. Bits [8:4] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Device address straps |
| sck_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| sen_i | input | 1 | Latch enable; a rising edge commits the frame |
| sdo_o | output | 1 | Serial readback data |
| sdo_en_o | output | 1 | Output enable for the readback pad |
| cfg_o | output | NREGS*9 | Register bank, register i at bits [9i+8:9i] |

## Verification
The 16th serial-clock rise and the latch-enable rise can be detected in the same system cycle. In that case the shift and the commit have to be resolved together. The bench provokes this by raising both pins in one drive step. The frame must commit with its final bit included, and the register bank is compared against the reference model on every clock once the frame has settled. The opposite case, a 17th rise followed by the latch, must be discarded, and the same per-clock comparison shows that the bank is unchanged.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

    localparam int REG_W   = 9;
    localparam int RADDR_W = 4;
    localparam int CHIP_W  = 3;
    localparam int FRAME_W = REG_W + RADDR_W + CHIP_W;
    localparam int PTR_W   = 4;

    localparam int PTR_IDX       = 0;
    localparam int CFG_IDX       = 4;
    localparam int BIT_BCAST     = 0;
    localparam int BIT_SYNC_PIN  = 1;
    localparam int BIT_SLIP_PIN  = 2;
    localparam int BIT_SOFT_RST  = 4;

    localparam logic [CHIP_W-1:0] BCAST_CHIP = '1;

    typedef logic [REG_W-1:0] cfg_word_t;

    typedef struct packed {
        cfg_word_t           data;
        logic [RADDR_W-1:0]  raddr;
        logic [CHIP_W-1:0]   chip;
    } frame_t;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_SHIFT,
        ST_ARMED,
        ST_OVER
    } frame_state_e;

    function automatic cfg_word_t reg_default(input int idx);
        cfg_word_t v;
        case (idx)
            1:       v = 9'h00F;
            2:       v = 9'h002;
            4:       v = 9'h002;
            6:       v = 9'h001;
            7:       v = 9'h004;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] pipe [STAGES+1];

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign level_o = pipe[STAGES-1];
    assign rise_o  = pipe[STAGES-1] & ~pipe[STAGES];

    // R1: an edge needs a low sample before it, so no bit rises twice in a row
    p_rise_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/cfgspi_frame_fsm.sv
module cfgspi_frame_fsm
    import cfgspi_pkg::*;
#(
    parameter int BITS = FRAME_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck_rise_i,
    input  logic            sen_level_i,
    input  logic            sen_rise_i,
    input  logic            sdi_i,
    output logic            start_o,
    output logic            commit_o,
    output logic            discard_o,
    output logic [BITS-1:0] frame_o
);

    localparam int CNT_W = $clog2(BITS + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_inc;
    logic [BITS-1:0]  sr_q, sr_next;

    always_comb begin
        cnt_inc = cnt_q + CNT_W'(sck_rise_i);
        sr_next = sck_rise_i ? {sr_q[BITS-2:0], sdi_i} : sr_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (!sen_level_i) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (sen_rise_i)          state_d = ST_HOLD;
                else if (cnt_inc == FULL) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (sen_rise_i)      state_d = ST_HOLD;
                else if (sck_rise_i) state_d = ST_OVER;
            end
            ST_OVER:  if (sen_rise_i) state_d = ST_HOLD;
            default:  state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        start_o   = 1'b0;
        commit_o  = 1'b0;
        discard_o = 1'b0;
        unique case (state_q)
            ST_HOLD:  start_o = !sen_level_i;
            ST_SHIFT: begin
                commit_o  = sen_rise_i && (cnt_inc == FULL);
                discard_o = sen_rise_i && (cnt_inc != FULL);
            end
            ST_ARMED: begin
                commit_o  = sen_rise_i && !sck_rise_i;
                discard_o = sen_rise_i && sck_rise_i;
            end
            ST_OVER:  discard_o = sen_rise_i;
            default:  ;
        endcase
    end

    assign frame_o = sr_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (start_o) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else begin
            if (state_q == ST_SHIFT || state_q == ST_ARMED) cnt_q <= cnt_inc;
            sr_q <= sr_next;
        end
    end

    // R4: an overrun frame never commits
    p_no_commit_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OVER) |-> !commit_o);
    // R4: a frame ends either committed or discarded, never both
    p_end_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && discard_o));
    // R1: a frame start clears the bit count
    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (cnt_q == '0 && state_q == ST_SHIFT));

endmodule

// File: rtl/cfgspi_regbank.sv
module cfgspi_regbank
    import cfgspi_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [RADDR_W-1:0]     wr_addr_i,
    input  cfg_word_t              wr_data_i,
    output logic [NREGS*REG_W-1:0] regs_o
);

    cfg_word_t bank_q [NREGS];
    logic      soft_req, pin_conflict, soft_q;

    always_comb begin
        soft_req     = wr_en_i && (wr_addr_i == RADDR_W'(PTR_IDX)) && wr_data_i[BIT_SOFT_RST];
        pin_conflict = (wr_addr_i == RADDR_W'(CFG_IDX))
                       && wr_data_i[BIT_SYNC_PIN] && wr_data_i[BIT_SLIP_PIN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) soft_q <= 1'b0;
        else        soft_q <= soft_req;
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam cfg_word_t KEEP = (g == PTR_IDX) ? cfg_word_t'((1 << PTR_W) - 1) : '1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q[g] <= reg_default(g);
            else if (soft_q)
                bank_q[g] <= reg_default(g);
            else if (wr_en_i && !soft_req && !pin_conflict && wr_addr_i == RADDR_W'(g))
                bank_q[g] <= wr_data_i & KEEP;
        end
        assign regs_o[g*REG_W +: REG_W] = bank_q[g];
    end

    // R8: the two pin-trigger enables are never on together
    p_pin_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_q[CFG_IDX][BIT_SYNC_PIN] && bank_q[CFG_IDX][BIT_SLIP_PIN]));
    // R9: one cycle after the pulse, the bank holds its defaults
    p_soft_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |=> (bank_q[PTR_IDX] == '0 && bank_q[CFG_IDX] == reg_default(CFG_IDX)
                    && bank_q[NREGS-1] == reg_default(NREGS-1)));
    // R11: the pointer register keeps only its low field
    p_ptr_narrow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q[PTR_IDX][REG_W-1:PTR_W] == '0);

endmodule

// File: rtl/cfgspi_readout.sv
module cfgspi_readout
    import cfgspi_pkg::*;
#(
    parameter int BITS = FRAME_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            shift_i,
    input  logic [BITS-1:0] word_i,
    output logic            sdo_o
);

    logic [BITS-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            sdo_o <= 1'b0;
        end else if (load_i) begin
            sr_q  <= word_i;
            sdo_o <= 1'b0;
        end else if (shift_i) begin
            sdo_o <= sr_q[BITS-1];
            sr_q  <= {sr_q[BITS-2:0], 1'b0};
        end
    end

    // R5: the serial output only moves on a clock rise or a frame start
    p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(sdo_o));

endmodule

// File: rtl/cfgspi_slave.sv
module cfgspi_slave
    import cfgspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NREGS       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CHIP_W-1:0]      strap_i,
    input  logic                   sck_i,
    input  logic                   sdi_i,
    input  logic                   sen_i,
    output logic                   sdo_o,
    output logic                   sdo_en_o,
    output logic [NREGS*REG_W-1:0] cfg_o
);

    localparam int PAD_W = FRAME_W - REG_W;

    logic [2:0]         lvl, rise;
    logic               unused_sync;
    logic               start, commit, discard;
    logic [FRAME_W-1:0] frame_bits;
    frame_t             frm;
    logic               own_hit, bcast_hit, accept;
    logic [PTR_W-1:0]   ptr;
    cfg_word_t          sel;
    logic [FRAME_W-1:0] rd_word;

    cfgspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sen_i, sck_i}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    assign unused_sync = lvl[0] ^ rise[2];

    cfgspi_frame_fsm #(.BITS(FRAME_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_rise_i  (rise[0]),
        .sen_level_i (lvl[1]),
        .sen_rise_i  (rise[1]),
        .sdi_i       (lvl[2]),
        .start_o     (start),
        .commit_o    (commit),
        .discard_o   (discard),
        .frame_o     (frame_bits)
    );

    always_comb begin
        frm       = frame_t'(frame_bits);
        own_hit   = (frm.chip == strap_i);
        bcast_hit = (frm.chip == BCAST_CHIP) && cfg_o[CFG_IDX*REG_W + BIT_BCAST];
        accept    = own_hit || bcast_hit;
    end

    cfgspi_regbank #(.NREGS(NREGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (commit && accept),
        .wr_addr_i (frm.raddr),
        .wr_data_i (frm.data),
        .regs_o    (cfg_o)
    );

    always_comb begin
        ptr = cfg_o[PTR_IDX*REG_W +: PTR_W];
        sel = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (ptr == PTR_W'(i)) sel = cfg_o[i*REG_W +: REG_W];
        end
        rd_word = {sel, PAD_W'(0)};
    end

    cfgspi_readout #(.BITS(FRAME_W)) u_readout (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .shift_i (rise[0]),
        .word_i  (rd_word),
        .sdo_o   (sdo_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sdo_en_o <= 1'b0;
        else if (commit) sdo_en_o <= own_hit;
    end

    // R2: a frame for another device leaves the bank untouched
    p_reject_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !accept) |=> $stable(cfg_o));
    // R3: the shared address is ignored while the opt-in bit is clear
    p_bcast_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frm.chip == BCAST_CHIP && strap_i != BCAST_CHIP
         && !cfg_o[CFG_IDX*REG_W + BIT_BCAST]) |=> $stable(cfg_o));
    // R6: the output enable moves only on a committed frame
    p_oe_on_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(sdo_en_o));
    // R4: a discarded frame changes no register
    p_discard_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> $stable(cfg_o));
    // R10: addresses beyond the bank change nothing
    p_high_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && 32'(frm.raddr) >= NREGS) |=> $stable(cfg_o));

endmodule

// File: tb/cfgspi_slave_tb_top.sv
module cfgspi_slave_tb_top;

    localparam int NREGS = 8;
    localparam logic [2:0] MY_CHIP    = 3'b010;
    localparam logic [2:0] OTHER_CHIP = 3'b101;
    localparam logic [2:0] ALL_CHIP   = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, sen = 1'b0;
    logic sdo, sdo_en;
    logic [NREGS*9-1:0] cfg;

    always #4 clk = ~clk;

    cfgspi_slave #(.SYNC_STAGES(2), .NREGS(NREGS)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (MY_CHIP),
        .sck_i    (sck),
        .sdi_i    (sdi),
        .sen_i    (sen),
        .sdo_o    (sdo),
        .sdo_en_o (sdo_en),
        .cfg_o    (cfg)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R7";
    logic [8:0] m_reg [NREGS];
    bit    m_oe = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] dflt(input int i);
        if (i == 1) return 9'h00F;
        if (i == 2) return 9'h002;
        if (i == 4) return 9'h002;
        if (i == 6) return 9'h001;
        if (i == 7) return 9'h004;
        return 9'h000;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NREGS; i++) m_reg[i] = dflt(i);
    endtask

    task automatic model_commit(input logic [15:0] w, input int nbits);
        logic [2:0] chip;
        logic [3:0] addr;
        logic [8:0] d;
        bit acc;
        if (nbits != 16) return;
        chip = w[2:0];
        addr = w[6:3];
        d    = w[15:7];
        m_oe = (chip == MY_CHIP);
        acc  = (chip == MY_CHIP) || (chip == ALL_CHIP && m_reg[4][0]);
        if (!acc) return;
        if (addr == 0) begin
            if (d[4]) model_reset();
            else      m_reg[0] = {5'b0, d[3:0]};
        end else if (int'(addr) < NREGS) begin
            if (!(addr == 4 && d[1] && d[2])) m_reg[addr] = d;
        end
    endtask

    function automatic logic [15:0] mk(input logic [8:0] d, input logic [3:0] a, input logic [2:0] c);
        return {d, a, c};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (cmp_en) begin
            for (int i = 0; i < NREGS; i++) check(cur_req, cfg[i*9 +: 9], m_reg[i]);
        end
    end

    task automatic frame(input logic [15:0] w, input int nbits, input bit merged, input string req);
        logic [15:0] rx;
        logic [15:0] exp;
        bit oe_before;
        int ptr;
        rx = '0;
        cur_req = req;
        oe_before = m_oe;
        ptr = int'(m_reg[0]);
        exp = (ptr < NREGS) ? {m_reg[ptr], 7'b0} : 16'h0000;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(4);
            if (merged && i == nbits - 1) begin
                cmp_en = 1'b0;
                sen = 1'b1;
            end
            sck = 1'b1;
            wait_clk(4);
            if (i < 16) rx[15-i] = sdo;
            if (i == 0) check({req, " (R6 output enable)"}, 32'(sdo_en), 32'(oe_before));
            sck = 1'b0;
        end
        if (!merged) begin
            wait_clk(4);
            cmp_en = 1'b0;
            sen = 1'b1;
        end
        wait_clk(8);
        model_commit(w, nbits);
        cmp_en = 1'b1;
        sen = 1'b0;
        wait_clk(8);
        if (oe_before && nbits >= 16) check({req, " (R5 readback word)"}, 32'(rx), 32'(exp));
    endtask

    initial begin
        model_reset();
        wait_clk(3);
        for (int i = 0; i < NREGS; i++) check("R7 default", cfg[i*9 +: 9], dflt(i));
        rst_n = 1'b1;
        cmp_en = 1'b1;
        wait_clk(10);
        check("R6 enable after reset", 32'(sdo_en), 32'd0);

        frame(mk(9'h1A5, 4'd7, MY_CHIP),    16, 1'b0, "R1");
        frame(mk(9'h0F0, 4'd2, OTHER_CHIP), 16, 1'b0, "R2");
        frame(mk(9'h007, 4'd0, MY_CHIP),    16, 1'b0, "R5");
        frame(mk(9'h003, 4'd1, MY_CHIP),    16, 1'b0, "R5");
        frame(mk(9'h055, 4'd3, ALL_CHIP),   16, 1'b0, "R3");
        frame(mk(9'h003, 4'd4, MY_CHIP),    16, 1'b0, "R3");
        frame(mk(9'h055, 4'd3, ALL_CHIP),   16, 1'b0, "R3");
        check("R3 broadcast write", cfg[3*9 +: 9], 9'h055);
        frame(mk(9'h1FF, 4'd5, MY_CHIP),    10, 1'b0, "R4");
        frame(mk(9'h1FF, 4'd5, MY_CHIP),    17, 1'b0, "R4");
        check("R4 short and long frames", cfg[5*9 +: 9], 9'h000);
        frame(mk(9'h0AA, 4'd6, MY_CHIP),    16, 1'b1, "R1");
        check("R1 coincident last edge", cfg[6*9 +: 9], 9'h0AA);
        frame(mk(9'h0AA, 4'd6, MY_CHIP),    17, 1'b1, "R4");
        frame(mk(9'h006, 4'd4, MY_CHIP),    16, 1'b0, "R8");
        check("R8 conflicting enables", cfg[4*9 +: 9], 9'h003);
        frame(mk(9'h005, 4'd4, MY_CHIP),    16, 1'b0, "R8");
        frame(mk(9'h123, 4'd9, MY_CHIP),    16, 1'b0, "R10");
        frame(mk(9'h009, 4'd0, MY_CHIP),    16, 1'b0, "R10");
        frame(mk(9'h000, 4'd2, MY_CHIP),    16, 1'b0, "R10");
        frame(mk(9'h1E6, 4'd0, MY_CHIP),    16, 1'b0, "R11");
        check("R11 pointer field only", cfg[8:0], 9'h006);
        frame(mk(9'h011, 4'd3, MY_CHIP),    16, 1'b0, "R11");
        frame(mk(9'h010, 4'd0, MY_CHIP),    16, 1'b0, "R9");
        check("R9 soft reset reg1", cfg[1*9 +: 9], 9'h00F);
        check("R9 soft reset reg4", cfg[4*9 +: 9], 9'h002);
        check("R9 soft reset reg0", cfg[8:0], 9'h000);
        frame(mk(9'h000, 4'd5, MY_CHIP),    16, 1'b0, "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule